// File: doc/BRIEF.md
# Multi-Ring Completion Interrupt Controller

This block gathers completion events from a set of transmit and receive rings and turns them into a single interrupt pulse. Each ring index has one transmit-done input, one receive-done input and one receive-overflow input, each a one-cycle pulse. An event sets its status bit only if software has enabled interrupts for that ring. The status bits form three bitfields (transmit done, receive done, receive overflow) packed back to back into 32-bit status words. Software reads a status word to collect and clear it in one access.

The interrupt works like a message: it is a single-cycle pulse, not a level. After a pulse the controller is disarmed. It arms again only once software has read every status word, including words whose bits all belong to disabled rings. If a bit is still pending when the controller arms again, a new pulse follows. A read-only word reports how many rings are built in.

The register port is a plain request/response port. A request (`req_valid`) is accepted in every cycle, with no back-pressure. A read returns its word on `rsp_rdata` with `rsp_valid` high exactly one cycle later. Writes produce no response. The event inputs and the interrupt output are plain control pins.

Top module: `ring_irq_ctrl`

## Requirements
- R1: After reset all enable bits are 0, all status bits are 0, the controller is armed, and `irq_pulse` and `rsp_valid` are low.
- R2: Enable words sit at word address EN_BASE+k (default 0). Transmit ring r uses enable bit r and receive ring r uses bit RINGS+r, counted across the words with bit n in word n/32, position n%32. A write replaces the word. A read returns it with every bit at or above 2·RINGS reading 0.
- R3: Status words sit at ST_BASE+k (default 8). Transmit-done of ring r is status bit r, receive-done is RINGS+r and receive-overflow is 2·RINGS+r, with bit n in word n/32, position n%32. Unused upper bits read 0.
- R4: An event sets its status bit only when the matching enable bit is 1 in the cycle the event arrives. A receive-overflow event uses the receive enable bit of its ring.
- R5: A read of a status word returns its contents and clears it in the same access. Writes to status words have no effect.
- R6: An event that arrives in the same cycle as a read of its status word is not lost: the read returns the old contents and the next read shows the new bit.
- R7: While the controller is armed, a set status bit raises `irq_pulse` for exactly one cycle. An event sampled at clock edge k gives `irq_pulse` high during the cycle after edge k+1.
- R8: After a pulse, no further pulse occurs until every status word has been read at least once, counting reads from the cycle in which the pulse is visible. The controller arms again at the edge that samples the last such read.
- R9: The ring-count word at HCNT_ADDR (default 16) reads RINGS in its low 11 bits and 0 above. Writes to it have no effect.
- R10: Every read gives `rsp_valid` high exactly one cycle later, with the word addressed by the request. Writes give no response. Unmapped addresses read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Register request present |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Word address |
| req_wdata | input | W | Write data |
| rsp_valid | output | 1 | Read data valid, one cycle after a read |
| rsp_rdata | output | W | Read data |
| tx_done_evt | input | RINGS | Transmit-done pulse per ring |
| rx_done_evt | input | RINGS | Receive-done pulse per ring |
| rx_ovf_evt | input | RINGS | Receive-overflow pulse per ring |
| irq_pulse | output | 1 | One-cycle interrupt message |

## Verification
The bench builds the block with RINGS=12 and W=32. This gives one 24-bit enable word and two status words, the second holding only the four overflow bits of rings 8 to 11. With only transmit rings enabled, that second word is made up entirely of disabled rings, so the rule that such a word must still be read before the controller re-arms can be tested directly. Random traffic mixes events with reads of both status words, reads of unmapped addresses and rewrites of the enable word. This covers events that coincide with reads and pulses that are held back while the controller is disarmed.

// File: rtl/ring_irq_pkg.sv
package ring_irq_pkg;

  // Number of W-bit words needed to hold a given number of bits.
  function automatic int words_for(input int bits, input int w);
    return (bits + w - 1) / w;
  endfunction

  // Which register group a request address falls into.
  typedef enum logic [1:0] {
    SEL_NONE,
    SEL_EN,
    SEL_ST,
    SEL_CNT
  } reg_sel_e;

endpackage

// File: rtl/ring_irq_enables.sv
module ring_irq_enables #(
  parameter int RINGS = 12,
  parameter int W     = 32,
  parameter int N_EN  = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N_EN-1:0]   wr_hit,
  input  logic [W-1:0]      wr_data,
  output logic [N_EN*W-1:0] en_o
);
  localparam int EN_BITS = 2 * RINGS;
  localparam int EN_PAD  = N_EN * W;

  // Only the first 2*RINGS bits get a flop; the padding above them is tied to 0.
  for (genvar b = 0; b < EN_PAD; b++) begin : g_bit
    if (b < EN_BITS) begin : g_live
      always_ff @(posedge clk) begin
        if (!rst_n)
          en_o[b] <= 1'b0;
        else if (wr_hit[b / W])
          en_o[b] <= wr_data[b % W];
      end
    end else begin : g_pad
      assign en_o[b] = 1'b0;
    end
  end
endmodule

// File: rtl/ring_irq_status.sv
module ring_irq_status #(
  parameter int RINGS = 12,
  parameter int W     = 32,
  parameter int N_ST  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [RINGS-1:0]  tx_evt,
  input  logic [RINGS-1:0]  rx_evt,
  input  logic [RINGS-1:0]  ovf_evt,
  input  logic [2*RINGS-1:0] en,
  input  logic [N_ST-1:0]   rd_hit,
  output logic [N_ST*W-1:0] stat_o
);
  localparam int ST_BITS = 3 * RINGS;
  localparam int ST_PAD  = N_ST * W;

  for (genvar b = 0; b < ST_PAD; b++) begin : g_bit
    if (b < ST_BITS) begin : g_live
      // Group 0 is transmit, 1 is receive, 2 is overflow; overflow shares the receive enable.
      localparam int GRP  = b / RINGS;
      localparam int RIDX = b % RINGS;
      logic set_b;
      if (GRP == 0) begin : g_tx
        assign set_b = tx_evt[RIDX] & en[RIDX];
      end else if (GRP == 1) begin : g_rx
        assign set_b = rx_evt[RIDX] & en[RINGS + RIDX];
      end else begin : g_ovf
        assign set_b = ovf_evt[RIDX] & en[RINGS + RIDX];
      end
      // The clear is applied before the new set, so an event in a read cycle survives.
      always_ff @(posedge clk) begin
        if (!rst_n)
          stat_o[b] <= 1'b0;
        else
          stat_o[b] <= (stat_o[b] & ~rd_hit[b / W]) | set_b;
      end
    end else begin : g_pad
      assign stat_o[b] = 1'b0;
    end
  end
endmodule

// File: rtl/ring_irq_arm.sv
module ring_irq_arm #(
  parameter int N_ST = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            any_pending,
  input  logic [N_ST-1:0] rd_hit,
  output logic            irq_o,
  output logic            armed_o
);
  logic [N_ST-1:0] seen_q, seen_next;
  logic            fire, all_seen;

  always_comb begin
    fire      = armed_o & any_pending;
    seen_next = seen_q | rd_hit;
    all_seen  = &seen_next;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      armed_o <= 1'b1;
      seen_q  <= '0;
      irq_o   <= 1'b0;
    end else begin
      irq_o <= fire;
      if (fire) begin
        armed_o <= 1'b0;
        seen_q  <= '0;
      end else if (!armed_o) begin
        if (all_seen) begin
          armed_o <= 1'b1;
          seen_q  <= '0;
        end else begin
          seen_q <= seen_next;
        end
      end
    end
  end
endmodule

// File: rtl/ring_irq_ctrl.sv
module ring_irq_ctrl
  import ring_irq_pkg::*;
#(
  parameter int RINGS     = 12,
  parameter int W         = 32,
  parameter int ADDR_W    = 5,
  parameter int EN_BASE   = 0,
  parameter int ST_BASE   = 8,
  parameter int HCNT_ADDR = 16,
  parameter int HCNT_W    = 11
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [W-1:0]      req_wdata,
  output logic              rsp_valid,
  output logic [W-1:0]      rsp_rdata,
  input  logic [RINGS-1:0]  tx_done_evt,
  input  logic [RINGS-1:0]  rx_done_evt,
  input  logic [RINGS-1:0]  rx_ovf_evt,
  output logic              irq_pulse
);
  localparam int N_EN   = words_for(2 * RINGS, W);
  localparam int N_ST   = words_for(3 * RINGS, W);
  localparam int EN_PAD = N_EN * W;
  localparam int ST_PAD = N_ST * W;
  localparam logic [HCNT_W-1:0] HCNT_VAL = HCNT_W'(RINGS);

  logic              rd_req, wr_req;
  logic [N_EN-1:0]   en_sel, en_wr_hit;
  logic [N_ST-1:0]   st_sel, rd_hit;
  logic              cnt_sel;
  reg_sel_e          sel;
  logic [EN_PAD-1:0] en_words;
  logic [2*RINGS-1:0] en_bits;
  logic [ST_PAD-1:0] stat_bits;
  logic [W-1:0]      rd_word;
  logic              armed;

  assign rd_req  = req_valid & ~req_write;
  assign wr_req  = req_valid & req_write;
  assign cnt_sel = (req_addr == ADDR_W'(HCNT_ADDR));
  assign en_bits = en_words[2*RINGS-1:0];

  for (genvar i = 0; i < N_EN; i++) begin : g_en_dec
    assign en_sel[i]    = (req_addr == ADDR_W'(EN_BASE + i));
    assign en_wr_hit[i] = wr_req & en_sel[i];
  end

  for (genvar i = 0; i < N_ST; i++) begin : g_st_dec
    assign st_sel[i] = (req_addr == ADDR_W'(ST_BASE + i));
    assign rd_hit[i] = rd_req & st_sel[i];
  end

  always_comb begin
    sel = SEL_NONE;
    if (|en_sel)      sel = SEL_EN;
    else if (|st_sel) sel = SEL_ST;
    else if (cnt_sel) sel = SEL_CNT;
  end

  always_comb begin
    rd_word = '0;
    case (sel)
      SEL_EN:
        for (int i = 0; i < N_EN; i++)
          if (en_sel[i]) rd_word = en_words[i*W +: W];
      SEL_ST:
        for (int i = 0; i < N_ST; i++)
          if (st_sel[i]) rd_word = stat_bits[i*W +: W];
      SEL_CNT: rd_word = W'(HCNT_VAL);
      default: rd_word = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_valid <= rd_req;
      if (rd_req) rsp_rdata <= rd_word;
    end
  end

  ring_irq_enables #(.RINGS(RINGS), .W(W), .N_EN(N_EN)) u_en (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_hit  (en_wr_hit),
    .wr_data (req_wdata),
    .en_o    (en_words)
  );

  ring_irq_status #(.RINGS(RINGS), .W(W), .N_ST(N_ST)) u_st (
    .clk     (clk),
    .rst_n   (rst_n),
    .tx_evt  (tx_done_evt),
    .rx_evt  (rx_done_evt),
    .ovf_evt (rx_ovf_evt),
    .en      (en_bits),
    .rd_hit  (rd_hit),
    .stat_o  (stat_bits)
  );

  ring_irq_arm #(.N_ST(N_ST)) u_arm (
    .clk         (clk),
    .rst_n       (rst_n),
    .any_pending (|stat_bits),
    .rd_hit      (rd_hit),
    .irq_o       (irq_pulse),
    .armed_o     (armed)
  );
endmodule

// File: rtl/ring_irq_ctrl_chk.sv
module ring_irq_ctrl_chk #(
  parameter int RINGS = 12,
  parameter int W     = 32,
  parameter int N_ST  = 2
) (
  input logic               clk,
  input logic               rst_n,
  input logic               req_valid,
  input logic               req_write,
  input logic               rsp_valid,
  input logic               irq_pulse,
  input logic [RINGS-1:0]   tx_evt,
  input logic [RINGS-1:0]   rx_evt,
  input logic [RINGS-1:0]   ovf_evt,
  input logic [2*RINGS-1:0] en,
  input logic [N_ST*W-1:0]  stat,
  input logic [N_ST-1:0]    rd_hit
);
  localparam int SB     = 3 * RINGS;
  localparam int ST_PAD = N_ST * W;

  logic [ST_PAD-1:0] en_spread, set_spread;
  logic [N_ST-1:0]   seen_chk;
  logic              had_irq;

  always_comb begin
    en_spread = '0;
    en_spread[SB-1:0] = {en[2*RINGS-1:RINGS], en[2*RINGS-1:RINGS], en[RINGS-1:0]};
    set_spread = '0;
    set_spread[SB-1:0] = {ovf_evt, rx_evt, tx_evt} & en_spread[SB-1:0];
  end

  // Status words read since the cycle in which the last pulse became visible.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      seen_chk <= '0;
      had_irq  <= 1'b0;
    end else begin
      seen_chk <= irq_pulse ? rd_hit : (seen_chk | rd_hit);
      if (irq_pulse) had_irq <= 1'b1;
    end
  end

  assert_irq_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
    irq_pulse |=> !irq_pulse);

  assert_irq_has_cause_R7: assert property (@(posedge clk) disable iff (!rst_n)
    irq_pulse |-> $past(|stat));

  assert_rearm_after_all_reads_R8: assert property (@(posedge clk) disable iff (!rst_n)
    irq_pulse |-> (!had_irq || (&$past(seen_chk))));

  assert_gated_set_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ((stat & ~$past(stat)) & ~$past(en_spread)) == '0);

  assert_rsp_on_read_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_write) |=> rsp_valid);

  assert_no_rsp_otherwise_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !(req_valid && !req_write) |=> !rsp_valid);

  for (genvar i = 0; i < N_ST; i++) begin : g_clr
    assert_clear_on_read_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_hit[i] && set_spread[i*W +: W] == '0) |=> stat[i*W +: W] == '0);
  end
endmodule

bind ring_irq_ctrl ring_irq_ctrl_chk #(.RINGS(RINGS), .W(W), .N_ST(N_ST)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_valid (req_valid),
  .req_write (req_write),
  .rsp_valid (rsp_valid),
  .irq_pulse (irq_pulse),
  .tx_evt    (tx_done_evt),
  .rx_evt    (rx_done_evt),
  .ovf_evt   (rx_ovf_evt),
  .en        (en_bits),
  .stat      (stat_bits),
  .rd_hit    (rd_hit)
);

// File: tb/sim_ring_irq_ctrl.sv
module sim_ring_irq_ctrl;
  localparam int RINGS = 12;
  localparam int W     = 32;
  localparam int AW    = 5;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          req_valid = 1'b0, req_write = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [W-1:0]  req_wdata = '0;
  logic          rsp_valid;
  logic [W-1:0]  rsp_rdata;
  logic [RINGS-1:0] tx_e = '0, rx_e = '0, ov_e = '0;
  logic          irq_pulse;

  always #10 clk = ~clk;  // 50 MHz

  ring_irq_ctrl #(.RINGS(RINGS), .W(W), .ADDR_W(AW)) u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .rsp_valid(rsp_valid),
    .rsp_rdata(rsp_rdata), .tx_done_evt(tx_e), .rx_done_evt(rx_e),
    .rx_ovf_evt(ov_e), .irq_pulse(irq_pulse)
  );

  int n_cmp = 0, n_bad = 0, cyc = 0;
  bit finished = 0;

  // Reference state, derived from the requirements.
  bit [23:0] m_en;
  bit [63:0] m_stat;
  bit        m_armed;
  bit [1:0]  m_seen;
  bit        e_irq, e_rv;
  bit [31:0] e_rd, last_rd;

  function automatic bit [31:0] ref_read(input bit [4:0] a);
    case (a)
      5'd0:    return {8'h0, m_en};
      5'd8:    return m_stat[31:0];
      5'd9:    return m_stat[63:32];
      5'd16:   return 32'd12;
      default: return 32'd0;
    endcase
  endfunction

  function automatic bit [63:0] ref_set(input bit [11:0] t, r, o);
    bit [63:0] s = '0;
    for (int h = 0; h < 12; h++) begin
      if (t[h] && m_en[h])      s[h]      = 1'b1;
      if (r[h] && m_en[12 + h]) s[12 + h] = 1'b1;
      if (o[h] && m_en[12 + h]) s[24 + h] = 1'b1;
    end
    return s;
  endfunction

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_cmp++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, got, exp);
    end
  endtask

  task automatic step(input bit v, input bit wr, input bit [4:0] a, input bit [31:0] d,
                      input bit [11:0] t, input bit [11:0] r, input bit [11:0] o);
    bit        rd;
    bit [1:0]  hit;
    bit [63:0] clr, setv;
    req_valid = v; req_write = wr; req_addr = a; req_wdata = d;
    tx_e = t; rx_e = r; ov_e = o;
    @(posedge clk);
    rd     = v && !wr;
    hit[0] = rd && (a == 5'd8);
    hit[1] = rd && (a == 5'd9);
    e_rv   = rd;
    if (rd) e_rd = ref_read(a);
    e_irq  = m_armed && (m_stat != 0);
    if (e_irq) begin
      m_armed = 0; m_seen = 0;
    end else if (!m_armed) begin
      if ((m_seen | hit) == 2'b11) begin
        m_armed = 1; m_seen = 0;
      end else m_seen = m_seen | hit;
    end
    clr = {{32{hit[1]}}, {32{hit[0]}}};
    setv = ref_set(t, r, o);
    m_stat = (m_stat & ~clr) | setv;
    if (v && wr && a == 5'd0) m_en = d[23:0];
    @(negedge clk);
    chk("R7/R8 irq_pulse", {31'b0, irq_pulse}, {31'b0, e_irq});
    chk("R10 rsp_valid", {31'b0, rsp_valid}, {31'b0, e_rv});
    if (e_rv) chk("R10 rsp_rdata", rsp_rdata, e_rd);
    last_rd = rsp_rdata;
    req_valid = 0; tx_e = '0; rx_e = '0; ov_e = '0;
  endtask

  task automatic rd_reg(input bit [4:0] a);
    step(1, 0, a, 0, 0, 0, 0);
  endtask

  task automatic wr_reg(input bit [4:0] a, input bit [31:0] d);
    step(1, 1, a, d, 0, 0, 0);
  endtask

  task automatic idle();
    step(0, 0, 0, 0, 0, 0, 0);
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000 && !finished) begin
      finished = 1;
      n_cmp++; n_bad++;
      $display("FAIL watchdog: run did not complete");
      summary();
    end
  end

  initial begin
    void'($urandom(32'd4711));
    m_en = '0; m_stat = '0; m_armed = 1; m_seen = '0;
    repeat (4) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R1 irq low after reset", {31'b0, irq_pulse}, 32'd0);
    chk("R1 rsp_valid low after reset", {31'b0, rsp_valid}, 32'd0);
    rd_reg(0);  chk("R1 enables cleared", last_rd, 32'd0);
    rd_reg(8);  chk("R1 status word0 cleared", last_rd, 32'd0);
    rd_reg(9);  chk("R1 status word1 cleared", last_rd, 32'd0);

    rd_reg(16); chk("R9 ring count", last_rd, 32'd12);
    wr_reg(16, 32'hFFFF_FFFF);
    rd_reg(16); chk("R9 ring count read-only", last_rd, 32'd12);
    wr_reg(8, 32'hFFFF_FFFF);
    rd_reg(8);  chk("R5 status not writable", last_rd, 32'd0);
    rd_reg(21); chk("R10 unmapped reads zero", last_rd, 32'd0);

    wr_reg(0, 32'hFFFF_FFFF);
    rd_reg(0);  chk("R2 enable width", last_rd, 32'h00FF_FFFF);

    // R4: transmit-only enables, receive and overflow events dropped.
    wr_reg(0, 32'h0000_0FFF);
    step(0, 0, 0, 0, 12'h008, 12'hFFF, 12'hFFF);
    idle();     chk("R7 pulse after event", {31'b0, irq_pulse}, 32'd1);
    idle();     chk("R7 pulse lasts one cycle", {31'b0, irq_pulse}, 32'd0);
    rd_reg(8);  chk("R4 only enabled tx bit", last_rd, 32'h0000_0008);
    rd_reg(9);  chk("R4 overflow gated by rx enable", last_rd, 32'd0);
    rd_reg(8);  chk("R5 cleared by read", last_rd, 32'd0);

    // R3 layout with everything enabled.
    wr_reg(0, 32'h00FF_FFFF);
    step(0, 0, 0, 0, 12'h020, 12'h004, 12'h800);
    idle(); idle();
    rd_reg(8);  chk("R3 tx and rx bit positions", last_rd, 32'h0000_4020);
    rd_reg(9);  chk("R3 overflow bit position", last_rd, 32'h0000_0008);

    // R6: event in the same cycle as the read of its word.
    rd_reg(9); rd_reg(8);
    step(1, 0, 8, 0, 0, 12'h001, 0);
    chk("R6 read before event", last_rd, 32'd0);
    rd_reg(8);  chk("R6 event kept", last_rd, 32'h0000_1000);
    rd_reg(9); rd_reg(8); rd_reg(9); idle();

    // R8: word 1 holds only disabled rings but must still be read.
    wr_reg(0, 32'h0000_0FFF);
    step(0, 0, 0, 0, 12'h001, 0, 0);
    idle();     chk("R8 first pulse", {31'b0, irq_pulse}, 32'd1);
    rd_reg(8);
    step(0, 0, 0, 0, 12'h002, 0, 0);
    idle();     chk("R8 held while word1 unread", {31'b0, irq_pulse}, 32'd0);
    idle();     chk("R8 still held", {31'b0, irq_pulse}, 32'd0);
    rd_reg(9);  chk("R8 disabled-only word reads zero", last_rd, 32'd0);
    idle();     chk("R8 pulse after all words read", {31'b0, irq_pulse}, 32'd1);
    rd_reg(8);  chk("R8 pending bit delivered", last_rd, 32'h0000_0002);
    rd_reg(9);

    // Random traffic against the reference.
    for (int n = 0; n < 4000; n++) begin
      int op = $urandom_range(0, 15);
      bit [11:0] t = 12'($urandom & $urandom & $urandom);
      bit [11:0] r = 12'($urandom & $urandom & $urandom);
      bit [11:0] o = 12'($urandom & $urandom & $urandom & $urandom);
      if (op < 5)       step(0, 0, 0, 0, t, r, o);
      else if (op < 9)  step(1, 0, 8, 0, t, r, o);
      else if (op < 12) step(1, 0, 9, 0, t, r, o);
      else if (op == 12) step(1, 1, 0, $urandom, t, r, o);
      else if (op == 13) step(1, 0, 0, 0, t, r, o);
      else if (op == 14) step(1, 0, 5'($urandom), 0, t, r, o);
      else               step(1, 1, 5'($urandom), $urandom, t, r, o);
    end

    finished = 1;
    summary();
  end
endmodule